// File: doc/BRIEF.md
# Queue doorbell write decoder

This block sits behind the register port of a multi-queue host interface and turns writes into the doorbell window into pointer updates. Each doorbell slot is four bytes wide. Submission and completion doorbells alternate: the even slot of a queue index moves that submission queue's tail, and the odd slot moves the completion queue's head. The block keeps the submission tail, completion head, completion tail, size and valid flag of every queue, along with the completion queue to which each submission queue reports.

A queue-management port loads the valid flag, the size and the binding of a queue, and clears its pointers. The completion poster reports its tail through a separate port. A read port returns the submission tail or the completion head of any queue. Accepted writes produce single-cycle kicks: one to the command fetcher per submission queue, one to the completion poster per completion queue, and an interrupt re-arm request per completion queue.

When a head write drains a completion queue that was full, work may have stalled behind it. The block therefore kicks every valid submission queue bound to that completion queue, and it kicks the completion poster as well.

Top module: `qdb_decoder`

## Requirements
- R1: A write is decoded only if its address is at or above the window base 0x1000 and its two low address bits are 0. Any other write changes no pointer and produces no kick or re-arm.
- R2: With off = address − 0x1000, the queue index is off >> 3. Bit 2 of off selects the target: 0 means submission tail and 1 means completion head. Submission q tail sits at 0x1000+8q and completion q head at 0x1004+8q.
- R3: A tail write to a valid submission queue carries a value below that queue's size. Such a write stores the value, which rd_ptr shows with rd_sel=0. It also sets sq_kick[q] for exactly the one cycle after the write edge.
- R4: A write is ignored, with the pointer kept and no output pulses, in each of these cases: the value is at or above the queue size, the target queue is not valid, or the index is NQ or more.
- R5: Only bits 15:0 of the write data form the pointer value; the upper bits have no effect.
- R6: On an accepted head write, the full test uses the tail and head held before the update: the queue is full when (tail+1) mod size equals head. If the queue was full, then in the next cycle sq_kick is high for every valid submission queue bound to it, and cq_kick[q] is also high.
- R7: An accepted head write to a completion queue that was not full produces no sq_kick and no cq_kick.
- R8: After an accepted head write, irq_rearm[q] pulses for one cycle if the completion tail differs from the new head. Otherwise it stays low.
- R9: A management write loads the valid flag and the size, plus the binding when the target is a submission queue. It resets that queue's pointers to 0. cfg_cq=1 selects a completion queue.
- R10: A completion tail update on the poster port is used by later full tests and by later re-arm decisions.
- R11: After reset, every queue is invalid, every pointer reads 0, and all kick and re-arm outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register byte address |
| wr_data | input | 32 | Register write data |
| cfg_we | input | 1 | Queue-management write strobe |
| cfg_cq | input | 1 | 1 = completion queue, 0 = submission queue |
| cfg_qid | input | QW | Queue index being configured |
| cfg_vld | input | 1 | Valid flag to load |
| cfg_size | input | PW | Queue size in entries |
| cfg_bind | input | QW | Completion queue of a submission queue |
| ct_we | input | 1 | Completion tail update strobe |
| ct_qid | input | QW | Completion queue index for the tail update |
| ct_val | input | PW | New completion tail |
| rd_sel | input | 1 | 0 = read submission tail, 1 = read completion head |
| rd_qid | input | QW | Queue index to read |
| rd_ptr | output | PW | Selected pointer value |
| sq_kick | output | NQ | Per-submission-queue fetch kick |
| cq_kick | output | NQ | Per-completion-queue poster kick |
| irq_rearm | output | NQ | Per-completion-queue interrupt re-arm request |

## Verification
The hardest case to reach is the wake-up of bound submission queues. A completion queue is full only when the poster's tail sits one entry behind the head. On top of that, the head write must land while that state holds. The stimulus binds two submission queues to one completion queue and moves the tail to size−1 with the head still at 0. A head write then fans out to both queues. A second full case is reached after the head has wrapped back to 0 with the tail at the last slot. Each doorbell write places its expected kick and re-arm vectors in a scoreboard queue. A monitor compares them in the cycle after the write and requires all outputs to be quiet in every other cycle.

// File: rtl/qdb_decoder.sv
module qdb_decoder #(
  parameter int NQ = 64,
  parameter int PW = 16,
  parameter int AW = 16,
  parameter logic [15:0] DB_BASE = 16'h1000,
  localparam int QW = $clog2(NQ)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic          cfg_we,
  input  logic          cfg_cq,
  input  logic [QW-1:0] cfg_qid,
  input  logic          cfg_vld,
  input  logic [PW-1:0] cfg_size,
  input  logic [QW-1:0] cfg_bind,
  input  logic          ct_we,
  input  logic [QW-1:0] ct_qid,
  input  logic [PW-1:0] ct_val,
  input  logic          rd_sel,
  input  logic [QW-1:0] rd_qid,
  output logic [PW-1:0] rd_ptr,
  output logic [NQ-1:0] sq_kick,
  output logic [NQ-1:0] cq_kick,
  output logic [NQ-1:0] irq_rearm
);

  logic [NQ-1:0] sq_vld, cq_vld;
  logic [PW-1:0] sq_size [NQ];
  logic [PW-1:0] sq_tail [NQ];
  logic [QW-1:0] sq_cq   [NQ];
  logic [PW-1:0] cq_size [NQ];
  logic [PW-1:0] cq_head [NQ];
  logic [PW-1:0] cq_tail [NQ];

  logic [AW-1:0] off;
  logic [AW-1:0] idx;
  logic [QW-1:0] qid;
  logic [PW-1:0] nv;
  logic          in_win, idx_ok, is_head, tail_ok, head_ok, was_full;
  logic [PW:0]   t_nxt;
  logic [NQ-1:0] wake;

  assign off     = wr_addr - AW'(DB_BASE);
  assign idx     = off >> 3;
  assign qid     = idx[QW-1:0];
  assign nv      = wr_data[PW-1:0];
  assign is_head = off[2];
  assign in_win  = wr_en && (wr_addr >= AW'(DB_BASE)) && (wr_addr[1:0] == 2'b00);
  assign idx_ok  = idx < AW'(NQ);
  assign tail_ok = in_win && idx_ok && !is_head && sq_vld[qid] && (nv < sq_size[qid]);
  assign head_ok = in_win && idx_ok &&  is_head && cq_vld[qid] && (nv < cq_size[qid]);

  assign t_nxt    = {1'b0, cq_tail[qid]} + 1'b1;
  assign was_full = (t_nxt == {1'b0, cq_size[qid]}) ? (cq_head[qid] == '0)
                                                   : (t_nxt[PW-1:0] == cq_head[qid]);

  for (genvar i = 0; i < NQ; i++) begin : g_wake
    assign wake[i] = sq_vld[i] && (sq_cq[i] == qid);
  end

  assign rd_ptr = rd_sel ? cq_head[rd_qid] : sq_tail[rd_qid];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_vld    <= '0;
      cq_vld    <= '0;
      sq_kick   <= '0;
      cq_kick   <= '0;
      irq_rearm <= '0;
      for (int i = 0; i < NQ; i++) begin
        sq_size[i] <= '0;
        sq_tail[i] <= '0;
        sq_cq[i]   <= '0;
        cq_size[i] <= '0;
        cq_head[i] <= '0;
        cq_tail[i] <= '0;
      end
    end else begin
      sq_kick   <= '0;
      cq_kick   <= '0;
      irq_rearm <= '0;
      if (tail_ok) begin
        sq_tail[qid] <= nv;
        sq_kick      <= NQ'(1) << qid;
      end
      if (head_ok) begin
        cq_head[qid] <= nv;
        if (was_full) begin
          sq_kick <= wake;
          cq_kick <= NQ'(1) << qid;
        end
        if (cq_tail[qid] != nv) irq_rearm <= NQ'(1) << qid;
      end
      if (ct_we) cq_tail[ct_qid] <= ct_val;
      if (cfg_we) begin
        if (cfg_cq) begin
          cq_vld[cfg_qid]  <= cfg_vld;
          cq_size[cfg_qid] <= cfg_size;
          cq_head[cfg_qid] <= '0;
          cq_tail[cfg_qid] <= '0;
        end else begin
          sq_vld[cfg_qid]  <= cfg_vld;
          sq_size[cfg_qid] <= cfg_size;
          sq_cq[cfg_qid]   <= cfg_bind;
          sq_tail[cfg_qid] <= '0;
        end
      end
    end
  end

endmodule

module qdb_decoder_chk #(
  parameter int NQ = 64,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [NQ-1:0] sq_kick,
  input logic [NQ-1:0] cq_kick,
  input logic [NQ-1:0] irq_rearm
);

  a_r1_misaligned_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[1:0] != 2'b00) |=> (sq_kick == '0 && cq_kick == '0 && irq_rearm == '0));

  a_r3_kick_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_kick != '0) |-> $past(wr_en));

  a_r3_tail_kick_single: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_kick != '0 && cq_kick == '0) |-> $onehot(sq_kick));

  a_r6_cq_kick_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cq_kick));

  a_r8_rearm_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_rearm));

  a_r8_rearm_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rearm != '0) |-> $past(wr_en));

endmodule

bind qdb_decoder qdb_decoder_chk #(.NQ(NQ), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .sq_kick(sq_kick), .cq_kick(cq_kick), .irq_rearm(irq_rearm)
);

// File: tb/test_qdb_decoder.sv
module test_qdb_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int NQ = 64;
  localparam int PW = 16;
  localparam int AW = 16;
  localparam int QW = $clog2(NQ);

  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic cfg_we = 0, cfg_cq = 0, cfg_vld = 0;
  logic [QW-1:0] cfg_qid = '0, cfg_bind = '0, ct_qid = '0, rd_qid = '0;
  logic [PW-1:0] cfg_size = '0, ct_val = '0;
  logic ct_we = 0, rd_sel = 0;
  logic [PW-1:0] rd_ptr;
  logic [NQ-1:0] sq_kick, cq_kick, irq_rearm;

  int total = 0, bad = 0;
  logic [NQ-1:0] q_sq[$], q_cq[$], q_irq[$];
  string q_tag[$];
  logic wr_q = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qdb_decoder #(.NQ(NQ), .PW(PW), .AW(AW)) i_qdb_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_we(cfg_we), .cfg_cq(cfg_cq), .cfg_qid(cfg_qid), .cfg_vld(cfg_vld),
    .cfg_size(cfg_size), .cfg_bind(cfg_bind), .ct_we(ct_we), .ct_qid(ct_qid),
    .ct_val(ct_val), .rd_sel(rd_sel), .rd_qid(rd_qid), .rd_ptr(rd_ptr),
    .sq_kick(sq_kick), .cq_kick(cq_kick), .irq_rearm(irq_rearm)
  );

  always @(posedge clk) wr_q <= rst_n && wr_en;

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_q && q_tag.size() > 0) begin
        logic [NQ-1:0] es, ec, ei;
        string t;
        es = q_sq.pop_front(); ec = q_cq.pop_front(); ei = q_irq.pop_front();
        t = q_tag.pop_front();
        total++;
        if (sq_kick !== es || cq_kick !== ec || irq_rearm !== ei) begin
          bad++;
          $display("FAIL %s: sq=%h cq=%h irq=%h expected sq=%h cq=%h irq=%h",
                   t, sq_kick, cq_kick, irq_rearm, es, ec, ei);
        end
      end else if (sq_kick !== '0 || cq_kick !== '0 || irq_rearm !== '0) begin
        total++; bad++;
        $display("FAIL R3 pulse width: sq=%h cq=%h irq=%h expected all 0",
                 sq_kick, cq_kick, irq_rearm);
      end
    end
  end

  task automatic db(input logic [AW-1:0] a, input logic [31:0] d,
                    input logic [NQ-1:0] es, input logic [NQ-1:0] ec,
                    input logic [NQ-1:0] ei, input string tag);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    q_sq.push_back(es); q_cq.push_back(ec); q_irq.push_back(ei); q_tag.push_back(tag);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic cfg(input logic cq, input int q, input logic v,
                     input int sz, input int b);
    @(negedge clk);
    cfg_we = 1; cfg_cq = cq; cfg_qid = QW'(q); cfg_vld = v;
    cfg_size = PW'(sz); cfg_bind = QW'(b);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic ctail(input int q, input int v);
    @(negedge clk);
    ct_we = 1; ct_qid = QW'(q); ct_val = PW'(v);
    @(negedge clk);
    ct_we = 0;
  endtask

  task automatic rd_chk(input logic s, input int q, input int exp, input string tag);
    @(negedge clk);
    rd_sel = s; rd_qid = QW'(q);
    #1;
    total++;
    if (rd_ptr !== PW'(exp)) begin
      bad++;
      $display("FAIL %s: rd_ptr=%0d expected %0d", tag, rd_ptr, exp);
    end
  endtask

  function automatic logic [NQ-1:0] b(input int i);
    return NQ'(1) << i;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (sq_kick !== '0 || cq_kick !== '0 || irq_rearm !== '0) begin
      bad++;
      $display("FAIL R11 reset outputs: sq=%h cq=%h irq=%h expected 0", sq_kick, cq_kick, irq_rearm);
    end
    rd_chk(0, 1, 0, "R11 reset tail");
    rd_chk(1, 1, 0, "R11 reset head");
    rst_n = 1;
    db(16'h1008, 32'd1, '0, '0, '0, "R11 invalid after reset");

    cfg(1, 1, 1, 4, 0);
    cfg(1, 2, 1, 8, 0);
    cfg(0, 1, 1, 8, 1);
    cfg(0, 2, 1, 4, 1);
    cfg(0, 3, 1, 8, 2);

    db(16'h1008, 32'd5, b(1), '0, '0, "R3 tail sq1");
    rd_chk(0, 1, 5, "R3 tail sq1 stored");
    db(16'h1010, 32'hABCD_0003, b(2), '0, '0, "R5 upper bits");
    rd_chk(0, 2, 3, "R5 tail sq2 low bits");
    db(16'h1010, 32'd4, '0, '0, '0, "R4 value at size");
    rd_chk(0, 2, 3, "R4 tail sq2 kept");
    db(16'h1028, 32'd1, '0, '0, '0, "R4 invalid queue");
    db(16'h1009, 32'd2, '0, '0, '0, "R1 misaligned");
    rd_chk(0, 1, 5, "R1 tail sq1 kept");
    db(16'h0008, 32'd2, '0, '0, '0, "R1 below base");
    db(16'h1200, 32'd0, '0, '0, '0, "R4 index NQ");
    rd_chk(0, 1, 5, "R2 tail sq1 kept after index NQ");

    ctail(1, 3);
    db(16'h100C, 32'd1, b(1) | b(2), b(1), b(1), "R6 full wake");
    rd_chk(1, 1, 1, "R2 head cq1 stored");
    db(16'h100C, 32'd3, '0, '0, '0, "R7 not full no rearm R8");
    db(16'h100C, 32'd4, '0, '0, '0, "R4 head at size");
    rd_chk(1, 1, 3, "R4 head cq1 kept");

    ctail(2, 2);
    db(16'h1014, 32'd1, '0, '0, b(2), "R8 rearm cq2");
    ctail(2, 7);
    db(16'h1014, 32'd0, '0, '0, b(2), "R10 new tail not full");
    db(16'h1014, 32'd0, b(3), b(2), b(2), "R6 wrap full");

    cfg(0, 1, 1, 8, 1);
    rd_chk(0, 1, 0, "R9 reconfig clears tail");
    cfg(1, 2, 0, 8, 0);
    db(16'h1014, 32'd1, '0, '0, '0, "R9 cq invalidated");
    rd_chk(1, 2, 0, "R9 cq2 head cleared");

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule